// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the serial side of a station management port. It runs on the management clock, watches the single management data line, and decodes clause-22 style frames. A read frame turns into a one-cycle read request on a parallel register port. The returned word is then shifted back onto the line. A write frame collects sixteen data bits and then issues a one-cycle write request with the address and the data.

The block answers to any station address, because the address field is captured but never compared. A frame begins when a 0 is sampled while idle. Further 0 bits hold the block waiting, and the first 1 after them opens the 12-bit header. The header holds the opcode, the station address and the register address, in that order, most significant bit first. A read uses a single turnaround bit, which the block drives low. A write uses two turnaround bits, which the block ignores.

Top module: `mdio_frame_slave`

## Requirements
- R1: A synchronous reset returns the block to idle. On the cycle after reset is sampled, `mdio_oe`, `rd_stb` and `wr_stb` are low.
- R2: While idle, sampled 1 bits have no effect. A sampled 0 arms frame detection, and any number of further 0 bits keep it armed. The first 1 after that opens a 12-bit header, taken MSB first as op[11:10], station address[9:5] and register address[4:0].
- R3: Header op 2'b10 is a read. In the cycle after the edge that samples header bit 0, `rd_stb` is high for exactly one cycle and `reg_addr` equals header bits [4:0]. The station address bits make no difference to this.
- R4: During the read turnaround bit, the cycle in which `rd_stb` is high, `mdio_oe` is 1 and `mdio_o` is 0. `rd_data` is captured at the edge that ends this bit.
- R5: After the turnaround bit, the 16 captured data bits appear on `mdio_o` MSB first, one per clock, with `mdio_oe` high. The block then drops `mdio_oe` and returns to idle.
- R6: Header op 2'b01 is a write. The block ignores the next two bits and shifts in 16 data bits MSB first. In the cycle after the edge that samples data bit 0, `wr_stb` is high for one cycle, with `reg_addr` equal to header bits [4:0] and `wr_data` equal to the 16 bits.
- R7: Header op 2'b00 or 2'b11 returns the block to idle with no strobe and no drive of the line. A following valid frame is decoded normally.
- R8: `mdio_oe` is high only during the read turnaround bit and the read data bits, and `rd_stb` and `wr_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; the line is sampled and driven on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Data driven onto the line during a read |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| reg_addr | output | 5 | Register address of the current access |
| rd_stb | output | 1 | One-cycle register read request |
| rd_data | input | 16 | Register read data, captured at the end of the turnaround bit |
| wr_stb | output | 1 | One-cycle register write request |
| wr_data | output | 16 | Register write data, valid while `wr_stb` is high |

## Verification
The bench drives each bit on a falling edge. It reads the outputs on the next falling edge, which is half a clock after the rising edge that acted on that bit. The read strobe, the register address and the low turnaround drive are due one sample after the last header bit. The sixteen data bits follow on the next sixteen samples, and the drive enable falls on the seventeenth. The write strobe is due one sample after the last data bit and must be gone on the sample after it. Each check is placed at exactly those samples, and the drive enable is also watched at every sample of a write frame and after a bad opcode.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_HDR,
    ST_RTA,
    ST_WTA,
    ST_RDAT,
    ST_WDAT
  } mdio_state_e;

  localparam int unsigned OP_W = 2;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return op == OP_READ;
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return op == OP_WRITE;
  endfunction

endpackage

// File: rtl/mdio_seq_fsm.sv
module mdio_seq_fsm
  import mdio_slave_pkg::*;
#(
  parameter int unsigned HDR_W  = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WTA_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic [OP_W-1:0]   hdr_op,
  output mdio_state_e       state,
  output logic              ev_start,
  output logic              ev_hdr_rd,
  output logic              ev_hdr_wr,
  output logic              ev_hdr_bad,
  output logic              ev_load,
  output logic              ev_wdone
);
  localparam int unsigned MAXC  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last       = (cnt == CNT_W'(1));
  assign ev_start   = (state == ST_ARM) && mdio_i;
  assign ev_hdr_rd  = (state == ST_HDR) && last && op_is_read(hdr_op);
  assign ev_hdr_wr  = (state == ST_HDR) && last && op_is_write(hdr_op);
  assign ev_hdr_bad = (state == ST_HDR) && last && !op_is_read(hdr_op) && !op_is_write(hdr_op);
  assign ev_load    = (state == ST_RTA);
  assign ev_wdone   = (state == ST_WDAT) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!mdio_i) state <= ST_ARM;
        ST_ARM: if (mdio_i) begin
          state <= ST_HDR;
          cnt   <= CNT_W'(HDR_W);
        end
        ST_HDR: begin
          cnt <= cnt - 1'b1;
          if (ev_hdr_rd) state <= ST_RTA;
          else if (ev_hdr_wr) begin
            state <= ST_WTA;
            cnt   <= CNT_W'(WTA_W);
          end else if (ev_hdr_bad) state <= ST_IDLE;
        end
        ST_RTA: begin
          state <= ST_RDAT;
          cnt   <= CNT_W'(DATA_W);
        end
        ST_WTA: begin
          cnt <= cnt - 1'b1;
          if (last) begin
            state <= ST_WDAT;
            cnt   <= CNT_W'(DATA_W);
          end
        end
        ST_RDAT, ST_WDAT: begin
          cnt <= cnt - 1'b1;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the header opens only from the armed state on a sampled 1
  a_r2_hdr_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && $past(state) != ST_HDR) |-> ($past(state) == ST_ARM && $past(mdio_i)));
  // R5: read data always follows exactly one turnaround bit
  a_r5_rdat_after_ta: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDAT && $past(state) != ST_RDAT) |-> $past(state) == ST_RTA);
  // R7: a bad opcode lands in idle
  a_r7_bad_op_idle: assert property (@(posedge clk) disable iff (rst)
    ev_hdr_bad |=> state == ST_IDLE);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] acc_next
);
  logic [W-1:0] acc;

  assign acc_next = {acc[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (shift_en) acc <= acc_next;
  end
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         msb
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= load_val;
    else if (shift_en) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mdio_frame_slave.sv
module mdio_frame_slave
  import mdio_slave_pkg::*;
#(
  parameter int unsigned PHY_W  = 5,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              mdc,
  input  logic              rst,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              rd_stb,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned HDR_W = OP_W + PHY_W + ADDR_W;
  localparam int unsigned SH_W  = (DATA_W > HDR_W) ? DATA_W : HDR_W;

  mdio_state_e     state;
  logic            ev_start, ev_hdr_rd, ev_hdr_wr, ev_hdr_bad, ev_load, ev_wdone;
  logic [SH_W-1:0] acc_next;
  logic            tx_msb;

  mdio_seq_fsm #(.HDR_W(HDR_W), .DATA_W(DATA_W), .WTA_W(2)) u_fsm (
    .clk(mdc), .rst(rst), .mdio_i(mdio_i),
    .hdr_op(acc_next[HDR_W-1 -: OP_W]),
    .state(state), .ev_start(ev_start), .ev_hdr_rd(ev_hdr_rd),
    .ev_hdr_wr(ev_hdr_wr), .ev_hdr_bad(ev_hdr_bad),
    .ev_load(ev_load), .ev_wdone(ev_wdone)
  );

  mdio_rx_shift #(.W(SH_W)) u_rx (
    .clk(mdc), .rst(rst), .clr(ev_start),
    .shift_en(state == ST_HDR || state == ST_WDAT),
    .bit_in(mdio_i), .acc_next(acc_next)
  );

  mdio_tx_shift #(.W(DATA_W)) u_tx (
    .clk(mdc), .rst(rst), .load(ev_load), .load_val(rd_data),
    .shift_en(state == ST_RDAT), .msb(tx_msb)
  );

  assign mdio_oe = (state == ST_RTA) || (state == ST_RDAT);
  assign mdio_o  = (state == ST_RDAT) ? tx_msb : 1'b0;

  always_ff @(posedge mdc) begin
    if (rst) begin
      reg_addr <= '0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
    end else begin
      rd_stb <= ev_hdr_rd;
      wr_stb <= ev_wdone;
      if (ev_hdr_rd || ev_hdr_wr) reg_addr <= acc_next[ADDR_W-1:0];
      if (ev_wdone) wr_data <= acc_next[DATA_W-1:0];
    end
  end

  // R1: outputs quiet on the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge mdc)
    rst |=> (!mdio_oe && !rd_stb && !wr_stb));
  // R3: read strobe lasts one cycle
  a_r3_rd_stb_single: assert property (@(posedge mdc) disable iff (rst)
    rd_stb |=> !rd_stb);
  // R4: turnaround bit is driven low while the read request is out
  a_r4_ta_low: assert property (@(posedge mdc) disable iff (rst)
    rd_stb |-> (mdio_oe && !mdio_o));
  // R6: write strobe lasts one cycle
  a_r6_wr_stb_single: assert property (@(posedge mdc) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R8: drive starts only with a read request, strobes exclusive
  a_r8_oe_start: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> rd_stb);
  a_r8_strobe_excl: assert property (@(posedge mdc) disable iff (rst)
    !(rd_stb && wr_stb));
endmodule

// File: tb/test_mdio_frame_slave.sv
`timescale 1ns/1ps
module test_mdio_frame_slave;
  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, rd_stb, wr_stb;
  logic [4:0]  reg_addr;
  logic [15:0] rd_data, wr_data;
  logic [15:0] regfile [32];
  logic [15:0] exp_mem [32];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 mdc = ~mdc;

  mdio_frame_slave i_mdio_frame_slave (
    .mdc(mdc), .rst(rst), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_addr(reg_addr), .rd_stb(rd_stb), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  function automatic logic [15:0] init_val(input int i);
    return 16'hC3A5 ^ (16'(i) * 16'h0101);
  endfunction

  // attached register file
  assign rd_data = regfile[reg_addr];
  always @(posedge mdc) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regfile[i] <= init_val(i);
    end else if (wr_stb) regfile[wr_addr_q()] <= wr_data;
  end
  function automatic logic [4:0] wr_addr_q();
    return reg_addr;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra, input int extra_zeros);
    logic [11:0] h;
    h = {op, phy, ra};
    put(1'b1); put(1'b1); put(1'b0);
    for (int k = 0; k < extra_zeros; k++) put(1'b0);
    put(1'b1);
    for (int k = 11; k >= 0; k--) put(h[k]);
  endtask

  task automatic do_read(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra, input int extra_zeros);
    logic [15:0] got;
    bit oe_ok;
    send_hdr(op, phy, ra, extra_zeros);
    @(negedge mdc);
    chk(rd_stb === 1'b1 && reg_addr === ra, "R3 read strobe/address", {rd_stb, 11'd0, reg_addr}, {1'b1, 11'd0, ra});
    chk(mdio_oe === 1'b1 && mdio_o === 1'b0, "R4 turnaround driven low", {mdio_oe, mdio_o}, 2'b10);
    mdio_i = 1'b1;
    oe_ok = 1;
    for (int k = 15; k >= 0; k--) begin
      @(negedge mdc);
      got[k] = mdio_o;
      if (mdio_oe !== 1'b1 || rd_stb !== 1'b0) oe_ok = 0;
    end
    chk(got === exp_mem[ra], "R5 read data MSB first", got, exp_mem[ra]);
    chk(oe_ok, "R5 oe held during data", 0, 1);
    @(negedge mdc);
    chk(mdio_oe === 1'b0, "R5 oe released after data", mdio_oe, 0);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    bit no_oe;
    no_oe = 1;
    send_hdr(2'b01, phy, ra, 0);
    put(1'b1); put(1'b0);
    if (mdio_oe !== 1'b0) no_oe = 0;
    for (int k = 15; k >= 0; k--) begin
      put(d[k]);
      if (mdio_oe !== 1'b0 || wr_stb !== 1'b0) no_oe = 0;
    end
    @(negedge mdc);
    chk(wr_stb === 1'b1 && reg_addr === ra && wr_data === d, "R6 write strobe/addr/data",
        {wr_stb, 10'd0, reg_addr, wr_data}, {1'b1, 10'd0, ra, d});
    mdio_i = 1'b1;
    @(negedge mdc);
    chk(wr_stb === 1'b0, "R6 write strobe one cycle", wr_stb, 0);
    chk(no_oe, "R8 no drive during write", 0, 1);
    exp_mem[ra] = d;
  endtask

  task automatic do_bad(input logic [1:0] op, input logic [4:0] ra);
    bit quiet;
    quiet = 1;
    send_hdr(op, 5'h00, ra, 0);
    put(1'b1);
    for (int k = 0; k < 20; k++) begin
      put(1'b1);
      if (mdio_oe !== 1'b0 || rd_stb !== 1'b0 || wr_stb !== 1'b0) quiet = 0;
    end
    chk(quiet, "R7 bad opcode makes no access", {mdio_oe, rd_stb, wr_stb}, 0);
  endtask

  // {op, phy, reg, data}
  localparam logic [27:0] VECS [12] = '{
    {2'b01, 5'h00, 5'h04, 16'h1234},
    {2'b10, 5'h1F, 5'h04, 16'h0000},
    {2'b01, 5'h0A, 5'h1F, 16'hFFFF},
    {2'b10, 5'h03, 5'h1F, 16'h0000},
    {2'b01, 5'h11, 5'h00, 16'h0001},
    {2'b10, 5'h00, 5'h00, 16'h0000},
    {2'b00, 5'h00, 5'h05, 16'h0000},
    {2'b11, 5'h00, 5'h06, 16'h0000},
    {2'b10, 5'h15, 5'h09, 16'h0000},
    {2'b01, 5'h0A, 5'h09, 16'h8000},
    {2'b10, 5'h1C, 5'h09, 16'h0000},
    {2'b10, 5'h00, 5'h05, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge mdc);
    chk(mdio_oe === 1'b0 && rd_stb === 1'b0 && wr_stb === 1'b0, "R1 reset state",
        {mdio_oe, rd_stb, wr_stb}, 0);
    rst = 1'b0;
    // R2: idle ones do nothing
    for (int k = 0; k < 6; k++) put(1'b1);
    @(negedge mdc);
    chk(mdio_oe === 1'b0 && rd_stb === 1'b0, "R2 ones in idle ignored", {mdio_oe, rd_stb}, 0);

    for (int v = 0; v < 12; v++) begin
      logic [27:0] e;
      e = VECS[v];
      case (e[27:26])
        2'b01:   do_write(e[25:21], e[20:16], e[15:0]);
        2'b10:   do_read(2'b10, e[25:21], e[20:16], 0);
        default: do_bad(e[27:26], e[20:16]);
      endcase
    end

    // R2: extra zeros before the start one
    do_read(2'b10, 5'h07, 5'h1F, 4);

    // R1: reset in the middle of a read
    send_hdr(2'b10, 5'h00, 5'h04, 0);
    put(1'b1); put(1'b1); put(1'b1);
    @(negedge mdc);
    rst = 1'b1;
    @(negedge mdc);
    chk(mdio_oe === 1'b0 && rd_stb === 1'b0 && wr_stb === 1'b0, "R1 reset mid-read",
        {mdio_oe, rd_stb, wr_stb}, 0);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) exp_mem[i] = init_val(i);
    do_read(2'b10, 5'h02, 5'h04, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule